// File: doc/BRIEF.md
# Bus-Hold Request Pin Controller

This block owns a single general-purpose port pin that can be handed over to a bus-hold protocol as an active-low bus-request output. It keeps three one-bit configuration registers for the pin: a function select, a drive (direction) bit and an output level. With the protocol off, the pin behaves as an ordinary port bit under those registers. It can also be pointed at the bus-request function through its function select.

When the bus-hold protocol enable input is high, the pin is forced to act as bus request, whatever the registers hold. The configuration is also frozen: writes made while the enable is high are thrown away, not queued. After the enable clears, the pin returns to the configuration it had before the enable was set. Bus request is computed from a register on the system clock. It goes low one clock after the hold state and the pending-external-cycle flag are both high. The hold and grant arbitration sits outside the block.

Top module: `busreq_pin_ctl`

## Requirements
- R1: After reset, the function select is 0 (port), the drive bit is 0 (pin released, `pin_oe` low), the level is 1 and the internal request is inactive.
- R2: With `hold_en` low, the function select 0 and the drive bit 1, `pin_oe` is high and `pin_o` equals the level register.
- R3: With `hold_en` low, the function select 0 and the drive bit 0, `pin_oe` is low (pin tri-stated).
- R4: While `hold_en` is high, `pin_oe` is high and `pin_o` carries the bus request, regardless of the three registers.
- R5: The bus request is active low. It is low in the cycle after a clock edge that sampled `hold_active` and `xfer_pending` both high, and high after any edge that sampled either one low.
- R6: A write with `cfg_we` high in a cycle where `hold_en` is high changes no register. Once `hold_en` clears, the pin behaves as it did before the enable was set.
- R7: A write with `cfg_we` high and `hold_en` low updates the selected register at that clock edge. `cfg_sel` 0 selects the function select, 1 the drive bit and 2 the level; `cfg_wdata` is the new value.
- R8: With `hold_en` low and the function select 1, `pin_oe` is high and `pin_o` carries the bus request.
- R9: A write with `cfg_sel` equal to 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_active | input | 1 | Bus is granted away (hold cycle in progress) |
| xfer_pending | input | 1 | Bus controller has an external cycle waiting |
| hold_en | input | 1 | Bus-hold protocol enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 function, 1 drive, 2 level, 3 none |
| cfg_wdata | input | 1 | Value written to the selected register |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench goes after the lock window. It sends writes to all three registers while the enable is high and then checks that the pin returns to its earlier level and direction. A design that queued or applied those writes would come back with the wrong drive or level. It checks the one-clock latency of the request with the hold state and pending flag rising separately and together. A design that dropped the request register, or gated it with a single input, would show the request a cycle early or with only one input high. It also checks the unused select code and the released pin in input direction. These catch a select decoder that aliases code 3 onto a real register and a mux that drives the pin while the direction is input.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int CFG_SEL_W = 2;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_FUNC  = 2'd0,
    SEL_DRIVE = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic func_req;  // 1: pin shows bus request
    logic drive;     // 1: pin driven
    logic level;     // value driven in port mode
  } pin_cfg_t;
endpackage

// File: rtl/pinctl_cfg_regs.sv
module pinctl_cfg_regs
  import pinctl_pkg::*;
#(
  parameter logic LEVEL_RST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock,
  input  logic                 we,
  input  logic [CFG_SEL_W-1:0] sel,
  input  logic                 wdata,
  output pin_cfg_t             cfg
);
  pin_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  assign cfg_en = we && !lock;

  always_comb begin
    cfg_d = cfg_q;
    unique case (cfg_sel_e'(sel))
      SEL_FUNC:  cfg_d.func_req = wdata;
      SEL_DRIVE: cfg_d.drive    = wdata;
      SEL_LEVEL: cfg_d.level    = wdata;
      SEL_NONE:  cfg_d          = cfg_q;
      default:   cfg_d          = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.func_req <= 1'b0;
      cfg_q.drive    <= 1'b0;
      cfg_q.level    <= LEVEL_RST;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/pinctl_req_gen.sv
module pinctl_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_active,
  input  logic xfer_pending,
  output logic req_q
);
  logic req_d;

  assign req_d = hold_active && xfer_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/pinctl_pin_mux.sv
module pinctl_pin_mux
  import pinctl_pkg::*;
(
  input  logic     hold_en,
  input  pin_cfg_t cfg,
  input  logic     req_q,
  output logic     pin_o,
  output logic     pin_oe
);
  logic show_req;

  assign show_req = hold_en || cfg.func_req;

  always_comb begin
    if (show_req) begin
      pin_o  = !req_q;
      pin_oe = 1'b1;
    end else begin
      pin_o  = cfg.level;
      pin_oe = cfg.drive;
    end
  end
endmodule

// File: rtl/busreq_pin_ctl.sv
module busreq_pin_ctl
  import pinctl_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic LEVEL_RST   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold_active,
  input  logic                 xfer_pending,
  input  logic                 hold_en,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic                 cfg_wdata,
  output logic                 pin_o,
  output logic                 pin_oe
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_sync_n;
  pin_cfg_t          cfg;
  logic              req_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= 1'b0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = rst_sync_q[SYNC_MSB];

  pinctl_cfg_regs #(.LEVEL_RST(LEVEL_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lock  (hold_en),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  pinctl_req_gen u_req (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .hold_active  (hold_active),
    .xfer_pending (xfer_pending),
    .req_q        (req_q)
  );

  pinctl_pin_mux u_mux (
    .hold_en (hold_en),
    .cfg     (cfg),
    .req_q   (req_q),
    .pin_o   (pin_o),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/busreq_pin_ctl_chk.sv
module busreq_pin_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_active,
  input logic       xfer_pending,
  input logic       hold_en,
  input logic       cfg_we,
  input logic [1:0] cfg_sel,
  input logic [2:0] cfg_bits,
  input logic       pin_o,
  input logic       pin_oe
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4
  hold_forces_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |-> pin_oe);

  // R5
  req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && hold_en) |-> (pin_o == !$past(hold_active && xfer_pending)));

  // R6
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> $stable(cfg_bits));

  // R3
  input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && !cfg_bits[2] && !cfg_bits[1]) |-> !pin_oe);

  // R2
  port_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && !cfg_bits[2] && cfg_bits[1]) |-> (pin_oe && pin_o == cfg_bits[0]));

  // R9
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> $stable(cfg_bits));
endmodule

bind busreq_pin_ctl busreq_pin_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .hold_active  (hold_active),
  .xfer_pending (xfer_pending),
  .hold_en      (hold_en),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_bits     (cfg),
  .pin_o        (pin_o),
  .pin_oe       (pin_oe)
);

// File: tb/test_busreq_pin_ctl.sv
module test_busreq_pin_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hold_active, xfer_pending, hold_en, cfg_we, cfg_wdata;
  logic [1:0] cfg_sel;
  logic       pin_o, pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic  oe;
    logic  o;
    bit    cmp_o;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  busreq_pin_ctl i_busreq_pin_ctl (
    .clk(clk), .rst_n(rst_n), .hold_active(hold_active),
    .xfer_pending(xfer_pending), .hold_en(hold_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // driver: apply one cycle of stimulus and queue the expected pin state
  task automatic step(input logic en, input logic hd, input logic pd,
                      input logic we, input logic [1:0] sel, input logic wd,
                      input logic e_oe, input logic e_o, input bit c_o,
                      input string tag);
    exp_t it;
    @(negedge clk);
    hold_en = en; hold_active = hd; xfer_pending = pd;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    it.oe = e_oe; it.o = e_o; it.cmp_o = c_o; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (pin_oe !== it.oe || (it.cmp_o && pin_o !== it.o)) begin
          failures++;
          $display("FAIL %s: oe=%b o=%b expected oe=%b o=%b", it.tag,
                   pin_oe, pin_o, it.oe, it.o);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hold_en = 0; hold_active = 0; xfer_pending = 0;
    cfg_we = 0; cfg_sel = 2'd0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // en hd pd we sel wd | oe o cmp
    step(0,0,0,0,2'd0,0, 0,0,0, "R1 reset pin released");
    step(0,1,1,0,2'd0,0, 0,0,0, "R1 port mode ignores request inputs");
    step(0,0,0,1,2'd1,1, 1,1,1, "R7 drive write, R2 level reset 1");
    step(0,0,0,1,2'd2,0, 1,0,1, "R2 level 0 driven");
    step(0,0,0,1,2'd1,0, 0,0,0, "R3 input direction released");
    step(0,0,0,1,2'd1,1, 1,0,1, "R7 drive back on");
    step(0,0,0,1,2'd3,1, 1,0,1, "R9 select 3 ignored");
    step(1,0,0,0,2'd0,0, 1,1,1, "R4 enable forces request high");
    step(1,1,0,1,2'd2,1, 1,1,1, "R5 hold alone no request");
    step(1,1,1,1,2'd1,0, 1,0,1, "R5 request low after both high");
    step(1,0,1,1,2'd0,1, 1,1,1, "R5 pending alone no request");
    step(1,0,0,1,2'd1,0, 1,1,1, "R4 request idle");
    step(0,0,0,0,2'd0,0, 1,0,1, "R6 config restored after unlock");
    step(0,1,1,1,2'd0,1, 1,0,1, "R8 function select request low");
    step(0,0,1,0,2'd0,0, 1,1,1, "R8 request released");
    step(0,0,0,1,2'd0,0, 1,0,1, "R7 back to port level 0");
    step(0,0,0,1,2'd1,0, 0,0,0, "R3 released again");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule